// File: doc/BRIEF.md
# External Debug Mode Controller

This block sits between a JTAG-driven emulation port and a processor core. It keeps the external debug mode flag and a debug-request flag in the test clock domain. From them it decides whether debug interrupts, debug events and watchpoints reach the core, and it raises a halt request when a debug-entry source is active. A global emulation-enable input takes priority over all of this. While that input is low the mode flag has no effect, and the block blocks every event, watchpoint and debug entry.

Register accesses arrive on a simple test-domain port. Three locations are held in the test domain itself: the command register, the control register and the mode flag. They accept writes even while the core clock is stopped. The other debug registers live in the core clock domain. An access to one of them is parked in a test-domain holding register and carried across with a toggle handshake through two-flop synchronizers. A busy flag stays up until the core domain acknowledges the access. Read data from the core domain is captured back into the test domain before it appears on the read port. One control bit asks the system clock controller to start the core clock, so that a parked write can complete.

Top module: `ext_debug_ctrl`

## Requirements
- R1: After both resets, the mode flag, the request bit, `clk_req`, `halt_req`, `t_busy`, `dbc_bits` and `aux_reg` are all zero.
- R2: Address 2 holds the debug control register, with the mode flag in its top bit. A write to address 2 while the mode flag is clear sets only the mode flag from that top bit. It starts no transfer, and the lower bits (`dbc_bits`) keep their values.
- R3: With `emu_en` high and the mode flag set, `dbg_int_out` stays low. With `emu_en` high and the mode flag clear, `dbg_int_out` follows `dbg_int_in`, and `evt_out`/`wpt_out` follow their inputs whatever the state of the mode flag.
- R4: With `emu_en` low, `dbg_int_out`, `evt_out` and `wpt_out` are zero, `halt_req` never asserts, and an active `halt_req` drops on the next core clock edge.
- R5: `halt_req` asserts from any of three sources. The first is bit 0 of the control register (address 1). The second is a write to the command register (address 0) with bit 0 set and bit 1 clear. The third is `dbg_entry_n` held low. A command write with bit 1 set requests nothing.
- R6: Once asserted, `halt_req` stays high until `core_halted` is seen, and it then falls on the next core clock edge. A halt request from a command write does not come back after it has been serviced.
- R7: The command and control registers are written and read back in the test domain with no core clock. A control read returns the request bit in bit 0 and the clock-request bit in bit 1. Bit 1 drives `clk_req`.
- R8: An access to address 3 (auxiliary register), or a write to address 2 while the mode flag is set, raises `t_busy` until the core domain acknowledges it. Another core-domain access made while `t_busy` is high is ignored. Command and control writes are still accepted during that time.
- R9: A core-domain write made while the core clock is stopped stays pending with `t_busy` high. It completes only after `clk_req` has been set and the clock runs.
- R10: A read of address 2 or 3 places the core-domain value on `t_rdata` in the cycle that `t_busy` falls. A read of address 2 shows the mode flag in the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst_n | input | 1 | Synchronous active-low reset, test domain |
| t_wr_en | input | 1 | Register write strobe |
| t_rd_en | input | 1 | Register read strobe |
| t_addr | input | 2 | Register address (0 command, 1 control, 2 debug control, 3 auxiliary) |
| t_wdata | input | DATA_W | Write data |
| t_rdata | output | DATA_W | Read data, test domain |
| t_busy | output | 1 | Core-domain access in flight |
| clk_req | output | 1 | Request to start the core clock |
| cclk | input | 1 | Core clock (may be stopped) |
| cclk_rst_n | input | 1 | Synchronous active-low reset, core domain |
| emu_en | input | 1 | Global emulation enable |
| dbg_entry_n | input | 1 | Asynchronous active-low debug entry pin |
| core_halted | input | 1 | Core reports it is halted in debug mode |
| dbg_int_in | input | 1 | Raw debug interrupt from the event logic |
| evt_in | input | NEVT | Raw debug event strobes |
| wpt_in | input | NWPT | Raw watchpoint strobes |
| dbg_int_out | output | 1 | Gated debug interrupt to the core |
| evt_out | output | NEVT | Gated debug events |
| wpt_out | output | NWPT | Gated watchpoints |
| halt_req | output | 1 | Debug-mode entry request to the core |
| dbc_bits | output | DATA_W-1 | Lower bits of the debug control register, core domain |
| aux_reg | output | DATA_W | Auxiliary debug register, core domain |

## Verification
A lost or doubled handshake toggle leaves `t_busy` stuck high, or lets a second access through. This shows within a few core clock cycles as an unchanged `aux_reg` or a value that is written twice. A wrong mode-flag update on the first set appears at once on `dbc_bits`, or as a `t_busy` pulse the test clock cycle after the write. Broken halt bookkeeping shows on `halt_req` within three or four core cycles of a source change or of `core_halted`: it fails to rise, fails to hold, or comes back after being serviced. A gating error is visible on the same cycle at the event, watchpoint and interrupt outputs.

// File: rtl/edc_pkg.sv
`timescale 1ns/1ps
// Package: shared address map and bit positions of the external debug controller.
// Assumes a two-bit register address on the test-domain access port.
package edc_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADR_CMD = 2'd0;   // command register, test domain
    localparam logic [ADDR_W-1:0] ADR_CTL = 2'd1;   // control register, test domain
    localparam logic [ADDR_W-1:0] ADR_DBC = 2'd2;   // mode flag (top bit) + core-domain bits
    localparam logic [ADDR_W-1:0] ADR_AUX = 2'd3;   // core-domain auxiliary register
    localparam int CMD_GO   = 0;
    localparam int CMD_EXIT = 1;
    localparam int CTL_DR   = 0;
    localparam int CTL_CLK  = 1;
endpackage

// File: rtl/edc_sync.sv
`timescale 1ns/1ps
// Module: single-bit multi-stage synchronizer with a selectable reset value.
// Assumes STAGES >= 2 and a slowly changing or toggle-coded input.
module edc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= {STAGES{RST_VAL}};
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/edc_tck_side.sv
`timescale 1ns/1ps
// Module: test-domain register file and handshake source.
// Holds command, control and mode flag; parks core-domain accesses in a
// holding register and signals them with a request toggle. Assumes ack_s is
// already synchronized and core_rdata is stable when the ack toggle arrives.
module edc_tck_side
    import edc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              edm,
    output logic              dr,
    output logic              clk_req,
    output logic              go_tgl,
    output logic              req_tgl,
    output logic              hold_wr,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_data,
    input  logic              ack_s,
    input  logic [DATA_W-1:0] core_rdata
);
    localparam int EDM_BIT = DATA_W - 1;

    logic              ack_seen;
    logic [DATA_W-1:0] cmd_q;
    logic              core_op;
    logic              start;

    // Decide whether this access must cross into the core domain.
    always_comb begin
        core_op = 1'b0;
        if (wr_en)      core_op = (addr == ADR_AUX) || ((addr == ADR_DBC) && edm);
        else if (rd_en) core_op = (addr == ADR_AUX) || (addr == ADR_DBC);
        start = core_op && !busy;
    end

    // Local registers, holding register, and completion of crossings.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            rdata     <= '0;
            busy      <= 1'b0;
            edm       <= 1'b0;
            dr        <= 1'b0;
            clk_req   <= 1'b0;
            go_tgl    <= 1'b0;
            req_tgl   <= 1'b0;
            hold_wr   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
            ack_seen  <= 1'b0;
            cmd_q     <= '0;
        end else begin
            if (ack_s != ack_seen) begin
                ack_seen <= ack_s;
                busy     <= 1'b0;
                if (!hold_wr)
                    rdata <= (hold_addr == ADR_DBC) ? {edm, core_rdata[EDM_BIT-1:0]} : core_rdata;
            end
            if (start) begin
                req_tgl   <= ~req_tgl;
                busy      <= 1'b1;
                hold_wr   <= wr_en;
                hold_addr <= addr;
                hold_data <= wdata;
            end
            if (wr_en) begin
                if (addr == ADR_CMD) begin
                    cmd_q <= wdata;
                    if (wdata[CMD_GO] && !wdata[CMD_EXIT]) go_tgl <= ~go_tgl;
                end
                if (addr == ADR_CTL) begin
                    dr      <= wdata[CTL_DR];
                    clk_req <= wdata[CTL_CLK];
                end
                if ((addr == ADR_DBC) && (!edm || !busy)) edm <= wdata[EDM_BIT];
            end else if (rd_en) begin
                if (addr == ADR_CMD) rdata <= cmd_q;
                if (addr == ADR_CTL) begin
                    rdata          <= '0;
                    rdata[CTL_DR]  <= dr;
                    rdata[CTL_CLK] <= clk_req;
                end
            end
        end
    end
endmodule

// File: rtl/edc_core_side.sv
`timescale 1ns/1ps
// Module: core-domain debug registers, handshake sink, event gating and halt request.
// Assumes all control inputs from the test domain arrive already synchronized
// and that hold_* stay stable while a request toggle is outstanding.
module edc_core_side
    import edc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NEVT   = 4,
    parameter int NWPT   = 2
) (
    input  logic              cclk,
    input  logic              rst_n,
    input  logic              req_s,
    input  logic              hold_wr,
    input  logic [ADDR_W-1:0] hold_addr,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              edm_s,
    input  logic              dr_s,
    input  logic              go_s,
    input  logic              entry_s_n,
    input  logic              core_halted,
    input  logic              emu_en,
    input  logic              dbg_int_in,
    input  logic [NEVT-1:0]   evt_in,
    input  logic [NWPT-1:0]   wpt_in,
    output logic              ack_tgl,
    output logic [DATA_W-1:0] rd_hold,
    output logic [DATA_W-2:0] dbc_lo,
    output logic [DATA_W-1:0] aux_q,
    output logic              dbg_int_out,
    output logic [NEVT-1:0]   evt_out,
    output logic [NWPT-1:0]   wpt_out,
    output logic              halt_req
);
    logic req_seen;
    logic go_seen;
    logic go_pend;
    logic entry_src;

    // Serve one crossed access per request toggle and answer with an ack toggle.
    always_ff @(posedge cclk) begin
        if (!rst_n) begin
            req_seen <= 1'b0;
            ack_tgl  <= 1'b0;
            rd_hold  <= '0;
            dbc_lo   <= '0;
            aux_q    <= '0;
        end else if (req_s != req_seen) begin
            req_seen <= req_s;
            ack_tgl  <= ~ack_tgl;
            if (hold_wr) begin
                if (hold_addr == ADR_DBC) dbc_lo <= hold_data[DATA_W-2:0];
                else                      aux_q  <= hold_data;
            end else begin
                rd_hold <= (hold_addr == ADR_DBC) ? {1'b0, dbc_lo} : aux_q;
            end
        end
    end

    assign entry_src = dr_s || go_pend || !entry_s_n;

    // Track the go-without-exit command and the held halt request.
    always_ff @(posedge cclk) begin
        if (!rst_n) begin
            go_seen  <= 1'b0;
            go_pend  <= 1'b0;
            halt_req <= 1'b0;
        end else begin
            go_seen <= go_s;
            if (go_s != go_seen)                        go_pend <= 1'b1;
            else if (!emu_en || (halt_req && core_halted)) go_pend <= 1'b0;
            if (halt_req) begin
                if (core_halted || !emu_en) halt_req <= 1'b0;
            end else if (emu_en && entry_src && !core_halted) begin
                halt_req <= 1'b1;
            end
        end
    end

    // Block everything without emulation enable; mode flag blocks interrupts.
    assign evt_out     = evt_in & {NEVT{emu_en}};
    assign wpt_out     = wpt_in & {NWPT{emu_en}};
    assign dbg_int_out = dbg_int_in && emu_en && !edm_s;
endmodule

// File: rtl/ext_debug_ctrl.sv
`timescale 1ns/1ps
// Module: external debug mode controller top.
// Joins the test-domain register side and the core-domain side through
// synchronizers. Assumes tck and cclk are unrelated and cclk may be stopped.
module ext_debug_ctrl
    import edc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NEVT   = 4,
    parameter int NWPT   = 2,
    parameter int SYNC_N = 2
) (
    input  logic              tck,
    input  logic              tck_rst_n,
    input  logic              t_wr_en,
    input  logic              t_rd_en,
    input  logic [ADDR_W-1:0] t_addr,
    input  logic [DATA_W-1:0] t_wdata,
    output logic [DATA_W-1:0] t_rdata,
    output logic              t_busy,
    output logic              clk_req,
    input  logic              cclk,
    input  logic              cclk_rst_n,
    input  logic              emu_en,
    input  logic              dbg_entry_n,
    input  logic              core_halted,
    input  logic              dbg_int_in,
    input  logic [NEVT-1:0]   evt_in,
    input  logic [NWPT-1:0]   wpt_in,
    output logic              dbg_int_out,
    output logic [NEVT-1:0]   evt_out,
    output logic [NWPT-1:0]   wpt_out,
    output logic              halt_req,
    output logic [DATA_W-2:0] dbc_bits,
    output logic [DATA_W-1:0] aux_reg
);
    logic              edm_t, dr_t, go_t, req_t, ack_c;
    logic              edm_c, dr_c, go_c, req_c, ent_c, ack_t;
    logic              hold_wr;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;
    logic [DATA_W-1:0] rd_hold;

    edc_tck_side #(.DATA_W(DATA_W)) u_tck (
        .tck(tck), .rst_n(tck_rst_n), .wr_en(t_wr_en), .rd_en(t_rd_en),
        .addr(t_addr), .wdata(t_wdata), .rdata(t_rdata), .busy(t_busy),
        .edm(edm_t), .dr(dr_t), .clk_req(clk_req), .go_tgl(go_t),
        .req_tgl(req_t), .hold_wr(hold_wr), .hold_addr(hold_addr),
        .hold_data(hold_data), .ack_s(ack_t), .core_rdata(rd_hold)
    );

    edc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_s_edm (.clk(cclk), .rst_n(cclk_rst_n), .d(edm_t), .q(edm_c));
    edc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_s_dr  (.clk(cclk), .rst_n(cclk_rst_n), .d(dr_t),  .q(dr_c));
    edc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_s_go  (.clk(cclk), .rst_n(cclk_rst_n), .d(go_t),  .q(go_c));
    edc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_s_req (.clk(cclk), .rst_n(cclk_rst_n), .d(req_t), .q(req_c));
    edc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_s_ent (.clk(cclk), .rst_n(cclk_rst_n), .d(dbg_entry_n), .q(ent_c));
    edc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_s_ack (.clk(tck),  .rst_n(tck_rst_n),  .d(ack_c), .q(ack_t));

    edc_core_side #(.DATA_W(DATA_W), .NEVT(NEVT), .NWPT(NWPT)) u_core (
        .cclk(cclk), .rst_n(cclk_rst_n), .req_s(req_c), .hold_wr(hold_wr),
        .hold_addr(hold_addr), .hold_data(hold_data), .edm_s(edm_c),
        .dr_s(dr_c), .go_s(go_c), .entry_s_n(ent_c), .core_halted(core_halted),
        .emu_en(emu_en), .dbg_int_in(dbg_int_in), .evt_in(evt_in), .wpt_in(wpt_in),
        .ack_tgl(ack_c), .rd_hold(rd_hold), .dbc_lo(dbc_bits), .aux_q(aux_reg),
        .dbg_int_out(dbg_int_out), .evt_out(evt_out), .wpt_out(wpt_out),
        .halt_req(halt_req)
    );
endmodule

// File: rtl/edc_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for ext_debug_ctrl, attached by bind.
// Assumes both resets are synchronous and active-low.
module edc_chk (
    input logic tck,
    input logic tck_rst_n,
    input logic t_wr_en,
    input logic t_rd_en,
    input logic t_busy,
    input logic clk_req,
    input logic cclk,
    input logic cclk_rst_n,
    input logic emu_en,
    input logic core_halted,
    input logic halt_req
);
    // R6
    halt_hold_chk: assert property (@(posedge cclk) disable iff (!cclk_rst_n)
        (halt_req && !core_halted && emu_en) |=> halt_req);

    // R6
    halt_clear_chk: assert property (@(posedge cclk) disable iff (!cclk_rst_n)
        (halt_req && core_halted) |=> !halt_req);

    // R4
    emu_block_chk: assert property (@(posedge cclk) disable iff (!cclk_rst_n)
        !emu_en |=> !halt_req);

    // R5
    halt_rise_chk: assert property (@(posedge cclk) disable iff (!cclk_rst_n)
        $rose(halt_req) |-> ($past(emu_en) && !$past(core_halted)));

    // R8
    busy_cause_chk: assert property (@(posedge tck) disable iff (!tck_rst_n)
        $rose(t_busy) |-> $past(t_wr_en || t_rd_en));

    // R7
    clkreq_steady_chk: assert property (@(posedge tck) disable iff (!tck_rst_n)
        !t_wr_en |=> $stable(clk_req));
endmodule

bind ext_debug_ctrl edc_chk u_chk (
    .tck(tck), .tck_rst_n(tck_rst_n), .t_wr_en(t_wr_en), .t_rd_en(t_rd_en),
    .t_busy(t_busy), .clk_req(clk_req), .cclk(cclk), .cclk_rst_n(cclk_rst_n),
    .emu_en(emu_en), .core_halted(core_halted), .halt_req(halt_req)
);

// File: tb/tb_ext_debug_ctrl.sv
`timescale 1ns/1ps
module tb_ext_debug_ctrl;
    logic       tck = 1'b0, cclk = 1'b0;
    logic       tck_rst_n = 1'b0, cclk_rst_n = 1'b0;
    logic       t_wr_en = 1'b0, t_rd_en = 1'b0;
    logic [1:0] t_addr = '0;
    logic [7:0] t_wdata = '0;
    logic [7:0] t_rdata;
    logic       t_busy, clk_req;
    logic       emu_en = 1'b1, dbg_entry_n = 1'b1, core_halted = 1'b0, dbg_int_in = 1'b0;
    logic [3:0] evt_in = '0, evt_out;
    logic [1:0] wpt_in = '0, wpt_out;
    logic       dbg_int_out, halt_req;
    logic [6:0] dbc_bits;
    logic [7:0] aux_reg;
    logic       gate = 1'b0;
    logic       cclk_on;
    int         total = 0, bad = 0, wd = 0;
    logic       done = 1'b0;
    logic [7:0] rd;
    logic       cur_edm = 1'b0;

    ext_debug_ctrl dut (
        .tck(tck), .tck_rst_n(tck_rst_n), .t_wr_en(t_wr_en), .t_rd_en(t_rd_en),
        .t_addr(t_addr), .t_wdata(t_wdata), .t_rdata(t_rdata), .t_busy(t_busy),
        .clk_req(clk_req), .cclk(cclk), .cclk_rst_n(cclk_rst_n), .emu_en(emu_en),
        .dbg_entry_n(dbg_entry_n), .core_halted(core_halted), .dbg_int_in(dbg_int_in),
        .evt_in(evt_in), .wpt_in(wpt_in), .dbg_int_out(dbg_int_out), .evt_out(evt_out),
        .wpt_out(wpt_out), .halt_req(halt_req), .dbc_bits(dbc_bits), .aux_reg(aux_reg)
    );

    // 125 MHz test clock; core clock gated by the modelled clock controller
    always #4 tck = ~tck;
    assign cclk_on = !gate || clk_req;
    always begin
        #5;
        if (cclk_on) cclk = ~cclk;
    end

    // {emu, edm, int_in, evt[4], wpt[2], exp_int, exp_evt[4], exp_wpt[2]}
    localparam logic [15:0] VEC [6] = '{
        {1'b1, 1'b0, 1'b1, 4'b1010, 2'b01, 1'b1, 4'b1010, 2'b01},
        {1'b1, 1'b1, 1'b1, 4'b0110, 2'b10, 1'b0, 4'b0110, 2'b10},
        {1'b0, 1'b1, 1'b1, 4'b1111, 2'b11, 1'b0, 4'b0000, 2'b00},
        {1'b0, 1'b0, 1'b1, 4'b0101, 2'b01, 1'b0, 4'b0000, 2'b00},
        {1'b1, 1'b1, 1'b0, 4'b1111, 2'b11, 1'b0, 4'b1111, 2'b11},
        {1'b1, 1'b0, 1'b0, 4'b0001, 2'b00, 1'b0, 4'b0001, 2'b00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge tck);
        t_addr = a; t_wdata = d; t_wr_en = 1'b1;
        @(negedge tck);
        t_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (t_busy) @(negedge tck);
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
        @(negedge tck);
        t_addr = a; t_rd_en = 1'b1;
        @(negedge tck);
        t_rd_en = 1'b0;
        wait_idle();
        d = t_rdata;
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge cclk);
    endtask

    task automatic set_edm(input logic v);
        wr(2'd2, {v, 7'h05});
        wait_idle();
        cur_edm = v;
        wait_c(4);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge tck) begin
        wd++;
        if (wd > 100000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", wd);
            finish_run();
        end
    end

    initial begin
        repeat (6) @(negedge tck);
        tck_rst_n = 1'b1; cclk_rst_n = 1'b1;
        @(negedge tck);
        // R1 reset state
        chk("R1 busy", t_busy, 0);
        chk("R1 clk_req", clk_req, 0);
        chk("R1 halt_req", halt_req, 0);
        chk("R1 dbc_bits", dbc_bits, 0);
        chk("R1 aux_reg", aux_reg, 0);
        rdreg(2'd1, rd); chk("R1 ctl", rd, 8'h00);
        rdreg(2'd2, rd); chk("R1 dbc", rd, 8'h00);

        // R7 local registers
        wr(2'd1, 8'h02); chk("R7 clk_req", clk_req, 1);
        rdreg(2'd1, rd); chk("R7 ctl read", rd, 8'h02);
        wr(2'd0, 8'h5C); rdreg(2'd0, rd); chk("R7 cmd read", rd, 8'h5C);

        // R8/R10 auxiliary write and read through the handshake
        wr(2'd3, 8'hA5);
        chk("R8 busy raised", t_busy, 1);
        wait_idle(); wait_c(2);
        chk("R8 aux written", aux_reg, 8'hA5);
        rdreg(2'd3, rd); chk("R10 aux read", rd, 8'hA5);

        // R2 first set of the mode flag leaves lower bits alone
        wr(2'd2, 8'hFF);
        chk("R2 no transfer", t_busy, 0);
        wait_c(4);
        chk("R2 low bits kept", dbc_bits, 7'h00);
        rdreg(2'd2, rd); chk("R2/R10 dbc read", rd, 8'h80);
        cur_edm = 1'b1;
        wr(2'd2, 8'h85);
        chk("R8 dbc busy", t_busy, 1);
        wait_idle(); wait_c(2);
        chk("R8 dbc bits", dbc_bits, 7'h05);
        rdreg(2'd2, rd); chk("R10 dbc read", rd, 8'h85);

        // R9 write with the core clock stopped, R8 second access ignored
        gate = 1'b1;
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h3C);
        wr(2'd3, 8'h77);
        repeat (40) @(negedge tck);
        chk("R9 still busy", t_busy, 1);
        chk("R9 not written", aux_reg, 8'hA5);
        wr(2'd1, 8'h02);
        chk("R8 ctl during busy", clk_req, 1);
        wait_idle(); wait_c(2);
        chk("R9 completed", aux_reg, 8'h3C);
        chk("R8 second ignored", aux_reg, 8'h3C);
        gate = 1'b0;

        // R3/R4 gating vectors
        foreach (VEC[i]) begin
            if (VEC[i][14] != cur_edm) set_edm(VEC[i][14]);
            emu_en = VEC[i][15]; dbg_int_in = VEC[i][13];
            evt_in = VEC[i][12:9]; wpt_in = VEC[i][8:7];
            @(negedge tck);
            chk($sformatf("R3/R4 int v%0d", i), dbg_int_out, VEC[i][6]);
            chk($sformatf("R3/R4 evt v%0d", i), evt_out, VEC[i][5:2]);
            chk($sformatf("R3/R4 wpt v%0d", i), wpt_out, VEC[i][1:0]);
        end
        emu_en = 1'b1; dbg_int_in = 1'b0; evt_in = '0; wpt_in = '0;

        // R5/R6 request bit source
        wr(2'd1, 8'h03); wait_c(6);
        chk("R5 dr halt", halt_req, 1);
        wait_c(4); chk("R6 held", halt_req, 1);
        core_halted = 1'b1; wait_c(2);
        chk("R6 cleared", halt_req, 0);
        wr(2'd1, 8'h02); wait_c(5);
        core_halted = 1'b0; wait_c(4);
        chk("R6 stays low", halt_req, 0);

        // R5/R6 entry pin
        dbg_entry_n = 1'b0; wait_c(5);
        chk("R5 pin halt", halt_req, 1);
        dbg_entry_n = 1'b1; wait_c(5);
        chk("R6 pin held", halt_req, 1);
        core_halted = 1'b1; wait_c(2);
        chk("R6 pin cleared", halt_req, 0);
        core_halted = 1'b0; wait_c(4);
        chk("R6 pin idle", halt_req, 0);

        // R5/R6 go without exit, and go with exit
        wr(2'd0, 8'h01); wait_c(6);
        chk("R5 go halt", halt_req, 1);
        core_halted = 1'b1; wait_c(2);
        chk("R6 go cleared", halt_req, 0);
        core_halted = 1'b0; wait_c(4);
        chk("R6 go not repeated", halt_req, 0);
        wr(2'd0, 8'h03); wait_c(6);
        chk("R5 go+exit none", halt_req, 0);

        // R4 emulation enable blocks entry
        dbg_entry_n = 1'b0; wait_c(5);
        chk("R4 pre halt", halt_req, 1);
        emu_en = 1'b0; wait_c(2);
        chk("R4 halt dropped", halt_req, 0);
        wait_c(4);
        chk("R4 blocked", halt_req, 0);
        dbg_entry_n = 1'b1; wait_c(4);
        emu_en = 1'b1; wait_c(4);
        chk("R4 restored idle", halt_req, 0);

        done = 1'b1;
        finish_run();
    end
endmodule